// File: doc/BRIEF.md
# Polled I/O Port Controller

This block sits on the device side of a polled I/O port. A host reaches it through four byte-wide registers on a small memory-mapped bus: a byte arriving from the device, a byte going to the device, a status word and a control word. The host and the controller pace each command with two flags. The host raises command-ready in the control word. The controller answers by raising busy. When the work is done, the controller lowers command-ready itself and settles the error flag, and only then drops busy.

A write command hands the outgoing byte to the device over a valid/ready pair. If the device does not take the byte within a bounded number of cycles, the controller gives up and reports an error. A read command waits for the device to offer a byte. It captures that byte into the incoming register and raises a data-available flag, which a host read of that register clears. The host polls the status word, issues a command only while busy is clear, and learns the outcome from the error flag once busy falls.

Top module: `pio_port_ctrl`

## Requirements
- R1: After a synchronous active-high reset, every register reads zero, busy is clear and `dev_tx_valid` is low.
- R2: The register map is: address 0 holds the incoming byte (read only); address 1 holds the outgoing byte (read/write); address 2 is status (read only), with busy at bit 0, data-available at bit 1 and error at bit 2; address 3 is control (read/write), with command-ready at bit 0, write at bit 1 and read at bit 2. `reg_rdata` shows the selected register in the same cycle and reads zero when `reg_sel` is low.
- R3: Host writes to address 1 or 3 are ignored while busy is set. Host writes to addresses 0 and 2 are always ignored.
- R4: When command-ready is set and busy is clear, busy is set on the next clock edge. No device activity starts before busy is set.
- R5: A write command presents the outgoing byte with `dev_tx_valid` and holds it stable until the device accepts it. The byte is handed over exactly once, on the cycle where valid and ready are both high.
- R6: On successful completion, command-ready and error are cleared while busy is still set, and busy clears one cycle later. The write and read bits in control are left as the host wrote them.
- R7: If a write byte is still not accepted after 16 cycles with valid high, valid drops, error is set, command-ready is cleared, and busy clears one cycle later.
- R8: A read command waits for `dev_rx_valid`, captures `dev_rx_data` into the incoming register, sets data-available, and then completes successfully.
- R9: A host read of address 0 clears data-available. If a device capture happens in the same cycle, the capture wins and data-available stays set.
- R10: If both the write and read bits are set, only the write is carried out. A command with neither bit set completes successfully with no device activity, which also clears a previous error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DW | Host write data |
| reg_rdata | output | DW | Read data for the selected register |
| dev_tx_valid | output | 1 | Outgoing byte is offered to the device |
| dev_tx_ready | input | 1 | Device accepts the outgoing byte |
| dev_tx_data | output | DW | Outgoing byte |
| dev_rx_valid | input | 1 | Device offers an incoming byte |
| dev_rx_data | input | DW | Incoming byte |

## Verification
The hardest case to reach from the ports is a host read of the incoming register landing in the very cycle the device's byte is captured. The capture can only happen while a read command is pending. The bench therefore issues a read command and waits for the controller to enter its waiting phase. On one falling edge it then raises both the address-0 read strobe and `dev_rx_valid`, and afterwards checks that data-available is still set. Holding a write command on a device that is not ready creates both the ignored-while-busy window and the timeout. The length of that window is measured by counting the cycles with valid high.

// File: rtl/pio_pkg.sv
package pio_pkg;
   localparam int unsigned ADDR_W = 2;

   localparam logic [ADDR_W-1:0] ADR_RXB  = 2'd0;
   localparam logic [ADDR_W-1:0] ADR_TXB  = 2'd1;
   localparam logic [ADDR_W-1:0] ADR_STAT = 2'd2;
   localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd3;

   localparam int unsigned CTL_CMD = 0;
   localparam int unsigned CTL_WR  = 1;
   localparam int unsigned CTL_RD  = 2;

   localparam int unsigned STS_BUSY  = 0;
   localparam int unsigned STS_AVAIL = 1;
   localparam int unsigned STS_ERR   = 2;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_DECODE,
      PH_SEND,
      PH_RECV,
      PH_DONE
   } phase_e;
endpackage

// File: rtl/pio_seq.sv
module pio_seq
   import pio_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic cmd_go,
   input  logic cmd_wr,
   input  logic cmd_rd,
   input  logic tx_ready,
   input  logic rx_valid,
   input  logic tmo_hit,
   output logic busy,
   output logic tx_act,
   output logic rx_act,
   output logic fin_ok,
   output logic fin_err,
   output logic rx_load
);
   phase_e ph_q, ph_d;

   always_ff @(posedge clk) begin
      if (rst) ph_q <= PH_IDLE;
      else     ph_q <= ph_d;
   end

   always_comb begin
      ph_d    = ph_q;
      fin_ok  = 1'b0;
      fin_err = 1'b0;
      rx_load = 1'b0;
      case (ph_q)
         PH_IDLE: begin
            if (cmd_go) ph_d = PH_DECODE;
         end
         PH_DECODE: begin
            if (cmd_wr)      ph_d = PH_SEND;
            else if (cmd_rd) ph_d = PH_RECV;
            else begin
               ph_d   = PH_DONE;
               fin_ok = 1'b1;
            end
         end
         PH_SEND: begin
            if (tx_ready) begin
               ph_d   = PH_DONE;
               fin_ok = 1'b1;
            end else if (tmo_hit) begin
               ph_d    = PH_DONE;
               fin_err = 1'b1;
            end
         end
         PH_RECV: begin
            if (rx_valid) begin
               ph_d    = PH_DONE;
               fin_ok  = 1'b1;
               rx_load = 1'b1;
            end
         end
         PH_DONE:  ph_d = PH_IDLE;
         default:  ph_d = PH_IDLE;
      endcase
   end

   assign busy   = (ph_q != PH_IDLE);
   assign tx_act = (ph_q == PH_SEND);
   assign rx_act = (ph_q == PH_RECV);
endmodule

// File: rtl/pio_tmo.sv
module pio_tmo #(
   parameter int unsigned TMO = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic act,
   input  logic ready,
   output logic hit
);
   generate
      if (TMO == 0) begin : g_off
         assign hit = 1'b0;
      end else begin : g_on
         localparam int unsigned CW = $clog2(TMO + 1);
         localparam logic [CW-1:0] LAST = CW'(TMO - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (rst || !act || ready) cnt_q <= '0;
            else if (cnt_q != LAST)   cnt_q <= cnt_q + 1'b1;
         end

         assign hit = act && !ready && (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/pio_regs.sv
module pio_regs
   import pio_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sel,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     rdata,
   input  logic              busy,
   input  logic              fin_ok,
   input  logic              fin_err,
   input  logic              rx_load,
   input  logic [DW-1:0]     rx_byte,
   output logic [DW-1:0]     txb_q,
   output logic [DW-1:0]     ctrl_q,
   output logic              avail_q,
   output logic              err_q
);
   logic [DW-1:0] rxb_q;
   logic [DW-1:0] stat_w;
   logic          host_wr, host_rd_rx;

   assign host_wr    = sel && wr && !busy;
   assign host_rd_rx = sel && !wr && (addr == ADR_RXB);

   always_ff @(posedge clk) begin
      if (rst) txb_q <= '0;
      else if (host_wr && addr == ADR_TXB) txb_q <= wdata;
   end

   always_ff @(posedge clk) begin
      if (rst) ctrl_q <= '0;
      else if (fin_ok || fin_err) ctrl_q[CTL_CMD] <= 1'b0;
      else if (host_wr && addr == ADR_CTRL) ctrl_q <= wdata;
   end

   always_ff @(posedge clk) begin
      if (rst) rxb_q <= '0;
      else if (rx_load) rxb_q <= rx_byte;
   end

   always_ff @(posedge clk) begin
      if (rst)             avail_q <= 1'b0;
      else if (rx_load)    avail_q <= 1'b1;
      else if (host_rd_rx) avail_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst)          err_q <= 1'b0;
      else if (fin_err) err_q <= 1'b1;
      else if (fin_ok)  err_q <= 1'b0;
   end

   generate
      if (DW == 3) begin : g_stat_tight
         assign stat_w = {err_q, avail_q, busy};
      end else begin : g_stat_pad
         assign stat_w = {{(DW-3){1'b0}}, err_q, avail_q, busy};
      end
   endgenerate

   always_comb begin
      rdata = '0;
      if (sel) begin
         case (addr)
            ADR_RXB:  rdata = rxb_q;
            ADR_TXB:  rdata = txb_q;
            ADR_STAT: rdata = stat_w;
            ADR_CTRL: rdata = ctrl_q;
            default:  rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/pio_port_ctrl.sv
module pio_port_ctrl
   import pio_pkg::*;
#(
   parameter int unsigned DW         = 8,
   parameter int unsigned TMO_CYCLES = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              reg_sel,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DW-1:0]     reg_wdata,
   output logic [DW-1:0]     reg_rdata,
   output logic              dev_tx_valid,
   input  logic              dev_tx_ready,
   output logic [DW-1:0]     dev_tx_data,
   input  logic              dev_rx_valid,
   input  logic [DW-1:0]     dev_rx_data
);
   generate
      if (DW < 3) begin : g_bad_dw
         $error("pio_port_ctrl: DW must be at least 3 to hold the flag bits");
      end
      if (TMO_CYCLES > 65535) begin : g_bad_tmo
         $error("pio_port_ctrl: TMO_CYCLES out of range");
      end
   endgenerate

   logic          busy, tx_act, rx_act;
   logic          fin_ok, fin_err, rx_load, tmo_hit;
   logic [DW-1:0] txb_q, ctrl_q;
   logic          avail_q, err_q, cmd_rdy;

   assign cmd_rdy = ctrl_q[CTL_CMD];

   pio_regs #(.DW(DW)) u_regs (
      .clk(clk), .rst(rst),
      .sel(reg_sel), .wr(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata),
      .busy(busy), .fin_ok(fin_ok), .fin_err(fin_err),
      .rx_load(rx_load), .rx_byte(dev_rx_data),
      .txb_q(txb_q), .ctrl_q(ctrl_q),
      .avail_q(avail_q), .err_q(err_q)
   );

   pio_seq u_seq (
      .clk(clk), .rst(rst),
      .cmd_go(cmd_rdy), .cmd_wr(ctrl_q[CTL_WR]), .cmd_rd(ctrl_q[CTL_RD]),
      .tx_ready(dev_tx_ready), .rx_valid(dev_rx_valid), .tmo_hit(tmo_hit),
      .busy(busy), .tx_act(tx_act), .rx_act(rx_act),
      .fin_ok(fin_ok), .fin_err(fin_err), .rx_load(rx_load)
   );

   pio_tmo #(.TMO(TMO_CYCLES)) u_tmo (
      .clk(clk), .rst(rst),
      .act(tx_act), .ready(dev_tx_ready), .hit(tmo_hit)
   );

   assign dev_tx_valid = tx_act;
   assign dev_tx_data  = txb_q;
endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk #(
   parameter int unsigned DW  = 8,
   parameter int unsigned TMO = 16
) (
   input logic          clk,
   input logic          rst,
   input logic          busy,
   input logic          cmd_rdy,
   input logic          err,
   input logic          avail,
   input logic          rx_act,
   input logic [DW-1:0] txb,
   input logic          dev_tx_valid,
   input logic          dev_tx_ready,
   input logic [DW-1:0] dev_tx_data,
   input logic          dev_rx_valid
);
   int unsigned stall_run;

   always_ff @(posedge clk) begin
      if (rst || !dev_tx_valid || dev_tx_ready) stall_run <= 0;
      else                                      stall_run <= stall_run + 1;
   end

   AST_GO_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
      !busy && cmd_rdy |=> busy); // R4
   AST_TX_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
      dev_tx_valid |-> busy); // R4
   AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
      dev_tx_valid && !dev_tx_ready |=> !dev_tx_valid || $stable(dev_tx_data)); // R5
   AST_ACCEPT_CLEAN: assert property (@(posedge clk) disable iff (rst)
      dev_tx_valid && dev_tx_ready |=> busy && !cmd_rdy && !err && !dev_tx_valid); // R6
   AST_BUSY_FALL: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> !cmd_rdy && !$past(dev_tx_valid)); // R6
   AST_TMO_WINDOW: assert property (@(posedge clk) disable iff (rst)
      dev_tx_valid && (TMO != 0) |-> stall_run < TMO); // R7
   AST_NO_HOST_EDIT: assert property (@(posedge clk) disable iff (rst)
      $past(busy) |-> $stable(txb)); // R3
   AST_RX_CAPTURE: assert property (@(posedge clk) disable iff (rst)
      rx_act && dev_rx_valid |=> avail && !err); // R8
endmodule

bind pio_port_ctrl pio_port_chk #(.DW(DW), .TMO(TMO_CYCLES)) u_chk (
   .clk(clk), .rst(rst), .busy(busy), .cmd_rdy(cmd_rdy), .err(err_q),
   .avail(avail_q), .rx_act(rx_act), .txb(txb_q),
   .dev_tx_valid(dev_tx_valid), .dev_tx_ready(dev_tx_ready),
   .dev_tx_data(dev_tx_data), .dev_rx_valid(dev_rx_valid)
);

// File: tb/sim_pio_port_ctrl.sv
module sim_pio_port_ctrl;
   localparam int CLK_P = 10;
   localparam int DW    = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          sel = 1'b0, wr = 1'b0;
   logic [1:0]    addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          tx_valid, tx_ready = 1'b0;
   logic [DW-1:0] tx_data;
   logic          rx_valid = 1'b0;
   logic [DW-1:0] rx_data = '0;

   int total = 0, bad = 0, vcount = 0;
   logic [DW-1:0] exp_q[$];
   logic [DW-1:0] v;

   always #(CLK_P/2) clk = ~clk;

   pio_port_ctrl #(.DW(DW), .TMO_CYCLES(16)) u0 (
      .clk(clk), .rst(rst), .reg_sel(sel), .reg_wr(wr), .reg_addr(addr),
      .reg_wdata(wdata), .reg_rdata(rdata),
      .dev_tx_valid(tx_valid), .dev_tx_ready(tx_ready), .dev_tx_data(tx_data),
      .dev_rx_valid(rx_valid), .dev_rx_data(rx_data)
   );

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [DW-1:0] d);
      @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk); sel = 1'b0; wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [DW-1:0] d);
      @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
      #1 d = rdata;
      @(negedge clk); sel = 1'b0;
   endtask

   task automatic wait_idle();
      logic [DW-1:0] s;
      for (int i = 0; i < 200; i++) begin
         bus_read(2'd2, s);
         if (!s[0]) break;
      end
   endtask

   // monitor: pops the scoreboard on each accepted byte, counts valid cycles
   always @(negedge clk) begin
      if (!rst && tx_valid) begin
         vcount++;
         if (tx_ready) begin
            total++;
            if (exp_q.size() == 0) begin
               bad++;
               $display("FAIL R5: actual=%h expected=<none>", tx_data);
            end else begin
               logic [DW-1:0] e;
               e = exp_q.pop_front();
               if (tx_data !== e) begin
                  bad++;
                  $display("FAIL R5: actual=%h expected=%h", tx_data, e);
               end
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         bus_read(a[1:0], v);
         check("R1", v, 8'h00);
      end
      check("R1 valid", {7'b0, tx_valid}, 8'h00);

      // R4/R5/R6: write with ready high, cycle by cycle
      tx_ready = 1'b1;
      exp_q.push_back(8'hA5);
      bus_write(2'd1, 8'hA5);
      bus_write(2'd3, 8'h03);
      sel = 1'b1; wr = 1'b0; addr = 2'd2;
      #1 check("R2 status idle", rdata, 8'h00);
      @(negedge clk); #1;
      check("R4 busy first", rdata, 8'h01);
      check("R4 no valid yet", {7'b0, tx_valid}, 8'h00);
      @(negedge clk); #1;
      check("R5 data", tx_data, 8'hA5);
      @(negedge clk); #1;
      check("R6 busy held", rdata, 8'h01);
      @(negedge clk); #1;
      check("R6 busy clear", rdata, 8'h00);
      sel = 1'b0;
      bus_read(2'd3, v);
      check("R6 ctrl", v, 8'h02);

      // R3: writes while busy are ignored
      tx_ready = 1'b0;
      exp_q.push_back(8'h3C);
      bus_write(2'd1, 8'h3C);
      bus_write(2'd3, 8'h03);
      @(negedge clk);
      bus_write(2'd1, 8'hC3);
      bus_write(2'd3, 8'h04);
      bus_read(2'd1, v);
      check("R3 txb kept", v, 8'h3C);
      bus_read(2'd3, v);
      check("R3 ctrl kept", v, 8'h03);
      tx_ready = 1'b1;
      wait_idle();
      bus_read(2'd2, v);
      check("R6 status ok", v, 8'h00);
      bus_write(2'd0, 8'h77);
      bus_read(2'd0, v);
      check("R3 rx reg ro", v, 8'h00);

      // R7: timeout
      tx_ready = 1'b0;
      vcount = 0;
      bus_write(2'd1, 8'h99);
      bus_write(2'd3, 8'h03);
      wait_idle();
      check("R7 valid cycles", vcount[7:0], 8'd16);
      bus_read(2'd2, v);
      check("R7 error", v, 8'h04);
      bus_read(2'd3, v);
      check("R7 ctrl", v, 8'h02);

      // R10: empty command clears error, no device activity
      tx_ready = 1'b1;
      vcount = 0;
      bus_write(2'd3, 8'h01);
      wait_idle();
      bus_read(2'd2, v);
      check("R10 empty cmd", v, 8'h00);
      check("R10 no tx", vcount[7:0], 8'd0);

      // R8: read command
      bus_write(2'd3, 8'h05);
      repeat (4) @(negedge clk);
      bus_read(2'd2, v);
      check("R8 waiting", v, 8'h01);
      @(negedge clk); rx_valid = 1'b1; rx_data = 8'h5A;
      @(negedge clk); rx_valid = 1'b0;
      wait_idle();
      bus_read(2'd2, v);
      check("R8 avail", v, 8'h02);
      bus_read(2'd0, v);
      check("R8 data", v, 8'h5A);
      bus_read(2'd2, v);
      check("R9 read clears", v, 8'h00);

      // R9: capture and host read in the same cycle
      bus_write(2'd3, 8'h05);
      repeat (3) @(negedge clk);
      @(negedge clk);
      sel = 1'b1; wr = 1'b0; addr = 2'd0; rx_valid = 1'b1; rx_data = 8'hC7;
      @(negedge clk);
      sel = 1'b0; rx_valid = 1'b0;
      wait_idle();
      bus_read(2'd2, v);
      check("R9 capture wins", v, 8'h02);
      bus_read(2'd0, v);
      check("R9 data", v, 8'hC7);

      // R10: both bits -> write only
      exp_q.push_back(8'h6E);
      bus_write(2'd1, 8'h6E);
      bus_write(2'd3, 8'h07);
      wait_idle();
      bus_read(2'd2, v);
      check("R10 both bits", v, 8'h00);
      bus_read(2'd3, v);
      check("R10 ctrl", v, 8'h06);
      repeat (2) @(negedge clk);
      check("R5 queue drained", exp_q.size() == 0 ? 8'h00 : 8'h01, 8'h00);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule